// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs a single asynchronous read or write access on an external parallel memory, either a NOR/SRAM-style device with a multiplexed 16-bit address/data bus or a NAND-style device with latch enables. Once a request is accepted, a cycle counter starts at zero. Each strobe (chip select, address valid / address latch, write enable, output enable) is asserted and released at cycle counts taken from its own programmable on/off fields. A global granularity flag doubles every count. A per-strobe flag moves both edges of that strobe half a functional clock later by re-timing it on the falling clock edge.

The host drives the timing fields and the request fields and pulses `req_start`. The block takes a copy of everything on the accepting edge. It ignores further starts until the access has finished, and it pulses `req_done` for one cycle at the end. For a read, the word on the memory bus is captured on the rising edge where output enable drops and held on `rd_data`. The memory bus is given as separate out/enable/in lanes so that a pad ring can build the bidirectional pin.

Top module: `async_strobe_seq`

## Requirements
- R1: Let E0 be the rising edge at which `req_start` is accepted. In the clock cycle that follows edge E0+t, a strobe is active exactly when on·m ≤ t < off·m and t < L, where m = 1. Chip select and address valid take their off count from the write field in a write and from the read field in a read.
- R2: With `cfg_gran`=1 the multiplier m is 2 for every on, off and cycle count.
- R3: Write enable (`mem_we_n`, active low) is active only in writes, inside its window. Output enable (`mem_oe_n`, active low) is active only in reads, inside its window. The two are never low together.
- R4: The access lasts L = c·m cycles, where c is the write or read cycle field and a field of 0 counts as 1. `req_done` is high only in the cycle after edge E0+L. From that edge on, every strobe is inactive.
- R5: Bit k of `cfg_xdly` (bit0 chip select, bit1 address valid/ALE/CLE, bit2 write enable, bit3 output enable) delays both edges of that strobe by half a clock. The strobe changes on the falling edge that follows the rising edge where it would otherwise change.
- R6: Only `mem_cs_n[req_cs]` goes low during its window. A `req_cs` of 6 or more asserts no chip select.
- R7: In a write, `mem_ad_oe` is 1 and `mem_ad_out` carries the write data for all L cycles. In a read, the bus is driven with the address only while the address-valid window is open. When the bus is released, `mem_ad_out` reads 0. The bus lanes never take the half-cycle delay.
- R8: `rd_data` loads `mem_ad_in` on the rising edge where the undelayed output-enable window closes, including the closing at the end of the access. It is unchanged by writes.
- R9: With `cfg_nand`=0, `mem_adv_ale` is the active-low address-valid window and `mem_be_cle` is low while chip select is active. With `cfg_nand`=1 both pins are active high: the address-valid window appears on `mem_adv_ale` when `req_cmd`=0 and on `mem_be_cle` when `req_cmd`=1.
- R10: A `req_start` during an access is ignored. Changes to request or timing inputs after E0 have no effect on the running access.
- R11: After reset all chip selects, `mem_adv_ale`, `mem_be_cle`, `mem_we_n` and `mem_oe_n` are high. `mem_ad_oe`, `req_done` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_start | input | 1 | request an access |
| req_write | input | 1 | 1 write, 0 read |
| req_cmd | input | 1 | NAND mode: latch phase is a command |
| req_cs | input | CS_IW | chip-select index |
| req_addr | input | AD_W | address word |
| req_wdata | input | AD_W | write word |
| req_done | output | 1 | one-cycle end-of-access pulse |
| rd_data | output | AD_W | captured read word |
| cfg_gran | input | 1 | double all counts |
| cfg_nand | input | 1 | NAND-style latch enables |
| cfg_xdly | input | 4 | half-cycle delay per strobe |
| cfg_cs_on | input | TW | chip-select on count |
| cfg_cs_wr_off | input | TW | chip-select off count, write |
| cfg_cs_rd_off | input | TW | chip-select off count, read |
| cfg_adv_on | input | TW | address-valid on count |
| cfg_adv_wr_off | input | TW | address-valid off count, write |
| cfg_adv_rd_off | input | TW | address-valid off count, read |
| cfg_we_on | input | TW | write-enable on count |
| cfg_we_off | input | TW | write-enable off count |
| cfg_oe_on | input | TW | output-enable on count |
| cfg_oe_off | input | TW | output-enable off count |
| cfg_wr_cycle | input | TW | write access length |
| cfg_rd_cycle | input | TW | read access length |
| mem_cs_n | output | NUM_CS | chip selects, active low |
| mem_adv_ale | output | 1 | address valid / ALE |
| mem_be_cle | output | 1 | byte enable / CLE |
| mem_we_n | output | 1 | write enable, active low |
| mem_oe_n | output | 1 | output enable, active low |
| mem_ad_out | output | AD_W | bus drive value |
| mem_ad_oe | output | 1 | bus drive enable |
| mem_ad_in | input | AD_W | bus read value |

## Verification
Every result is timed from the accepting edge E0. Undelayed strobes and the bus lanes for time t are valid just after edge E0+t. A half-delayed strobe still shows time t−1 until the falling edge and shows time t after it. `req_done` appears after edge E0+L, and `rd_data` after the edge where output enable closes. The monitor therefore samples twice per cycle: 2 ns after the rising edge, where only the half-delayed strobes are held back one step, and 7 ns after it, where everything reflects time t. It keeps checking until edge E0+L+1, so the end pulse and the captured read word are both covered.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam int TV_W = 16;

  localparam int STB_CS  = 0;
  localparam int STB_ADV = 1;
  localparam int STB_WE  = 2;
  localparam int STB_OE  = 3;
  localparam int STB_N   = 4;

  // programmed count times the granularity multiplier
  function automatic logic [TV_W:0] scale_time(input logic [TV_W-1:0] v, input logic g);
    return g ? {v, 1'b0} : {1'b0, v};
  endfunction

  // strobe window: active from scaled on count up to (not incl.) scaled off count
  function automatic logic in_window(input logic [TV_W:0] t, input logic [TV_W-1:0] on_t,
                                     input logic [TV_W-1:0] off_t, input logic g);
    return (t >= scale_time(on_t, g)) && (t < scale_time(off_t, g));
  endfunction
endpackage

// File: rtl/asq_latch.sv
module asq_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] eff
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // on the loading edge the live value is already the one in force
  assign eff = load ? d : q;
endmodule

// File: rtl/asq_timer.sv
module asq_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [CW-1:0] len,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic          busy_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign accept   = req_start && !busy;
  assign last     = busy && (cnt == len - 1'b1);
  assign busy_nxt = accept || (busy && !last);
  assign cnt_nxt  = accept ? '0 : (busy ? cnt + 1'b1 : cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_nxt;
      cnt  <= cnt_nxt;
      done <= last;
    end
  end
endmodule

// File: rtl/asq_half_delay.sv
module asq_half_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  input  logic lvl_in,
  output logic lvl_out
);
  logic lvl_neg;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lvl_neg <= 1'b0;
    else        lvl_neg <= lvl_in;
  end

  assign lvl_out = half_en ? lvl_neg : lvl_in;
endmodule

// File: rtl/async_strobe_seq.sv
module async_strobe_seq #(
  parameter int TW     = 5,
  parameter int NUM_CS = 6,
  parameter int AD_W   = 16,
  parameter int CS_IW  = $clog2(NUM_CS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic [CS_IW-1:0]  req_cs,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              req_done,
  output logic [AD_W-1:0]   rd_data,
  input  logic              cfg_gran,
  input  logic              cfg_nand,
  input  logic [3:0]        cfg_xdly,
  input  logic [TW-1:0]     cfg_cs_on,
  input  logic [TW-1:0]     cfg_cs_wr_off,
  input  logic [TW-1:0]     cfg_cs_rd_off,
  input  logic [TW-1:0]     cfg_adv_on,
  input  logic [TW-1:0]     cfg_adv_wr_off,
  input  logic [TW-1:0]     cfg_adv_rd_off,
  input  logic [TW-1:0]     cfg_we_on,
  input  logic [TW-1:0]     cfg_we_off,
  input  logic [TW-1:0]     cfg_oe_on,
  input  logic [TW-1:0]     cfg_oe_off,
  input  logic [TW-1:0]     cfg_wr_cycle,
  input  logic [TW-1:0]     cfg_rd_cycle,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_adv_ale,
  output logic              mem_be_cle,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [AD_W-1:0]   mem_ad_out,
  output logic              mem_ad_oe,
  input  logic [AD_W-1:0]   mem_ad_in
);
  import asq_pkg::*;

  localparam int CW = TW + 1;
  localparam int LW = 12 * TW + 8 + CS_IW + 2 * AD_W;

  // ---------------- request/configuration snapshot ----------------
  logic [LW-1:0] cfg_live, cfg_eff;
  logic [TW-1:0] e_cs_on, e_cs_wo, e_cs_ro, e_adv_on, e_adv_wo, e_adv_ro;
  logic [TW-1:0] e_we_on, e_we_off, e_oe_on, e_oe_off, e_wcyc, e_rcyc;
  logic          e_gran, e_nand, e_write, e_cmd;
  logic [3:0]    e_xdly;
  logic [CS_IW-1:0] e_cs;
  logic [AD_W-1:0]  e_addr, e_wdata;

  assign cfg_live = {cfg_cs_on, cfg_cs_wr_off, cfg_cs_rd_off, cfg_adv_on, cfg_adv_wr_off,
                     cfg_adv_rd_off, cfg_we_on, cfg_we_off, cfg_oe_on, cfg_oe_off,
                     cfg_wr_cycle, cfg_rd_cycle, cfg_gran, cfg_nand, cfg_xdly,
                     req_write, req_cmd, req_cs, req_addr, req_wdata};
  assign {e_cs_on, e_cs_wo, e_cs_ro, e_adv_on, e_adv_wo, e_adv_ro, e_we_on, e_we_off,
          e_oe_on, e_oe_off, e_wcyc, e_rcyc, e_gran, e_nand, e_xdly,
          e_write, e_cmd, e_cs, e_addr, e_wdata} = cfg_eff;

  logic accept, busy, last, busy_nxt;
  logic [CW-1:0] cnt_nxt, acc_len;

  asq_latch #(.W(LW)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(accept), .d(cfg_live), .eff(cfg_eff)
  );

  // ---------------- access length ----------------
  logic [TW-1:0] cyc_sel, cyc_min;
  logic [TV_W:0] len_scaled;
  assign cyc_sel    = e_write ? e_wcyc : e_rcyc;
  assign cyc_min    = (cyc_sel == '0) ? {{(TW-1){1'b0}}, 1'b1} : cyc_sel;
  assign len_scaled = scale_time(TV_W'(cyc_min), e_gran);
  assign acc_len    = len_scaled[CW-1:0];

  asq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .len(acc_len),
    .accept(accept), .busy(busy), .last(last), .busy_nxt(busy_nxt),
    .cnt_nxt(cnt_nxt), .done(req_done)
  );

  // ---------------- strobe windows ----------------
  logic [TW-1:0] on_a  [STB_N];
  logic [TW-1:0] off_a [STB_N];
  logic [STB_N-1:0] gate_a, lvl_nxt, lvl_q, lvl_d;

  always_comb begin
    on_a[STB_CS]   = e_cs_on;
    off_a[STB_CS]  = e_write ? e_cs_wo : e_cs_ro;
    gate_a[STB_CS] = 1'b1;
    on_a[STB_ADV]  = e_adv_on;
    off_a[STB_ADV] = e_write ? e_adv_wo : e_adv_ro;
    gate_a[STB_ADV] = 1'b1;
    on_a[STB_WE]   = e_we_on;
    off_a[STB_WE]  = e_we_off;
    gate_a[STB_WE] = e_write;
    on_a[STB_OE]   = e_oe_on;
    off_a[STB_OE]  = e_oe_off;
    gate_a[STB_OE] = !e_write;
  end

  // named internal event: output-enable window closes on this edge
  logic oe_fall;
  assign oe_fall = lvl_q[STB_OE] && !lvl_nxt[STB_OE];

  // delay-select and pin-decode fields held for the running access
  logic             pin_nand, pin_cmd;
  logic [3:0]       pin_xdly;
  logic [CS_IW-1:0] pin_cs;

  for (genvar k = 0; k < STB_N; k++) begin : g_stb
    assign lvl_nxt[k] = busy_nxt && gate_a[k] &&
                        in_window(TV_W'(cnt_nxt) + {(TV_W+1){1'b0}}, TV_W'(on_a[k]),
                                  TV_W'(off_a[k]), e_gran);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[k] <= 1'b0;
      else        lvl_q[k] <= lvl_nxt[k];
    end

    asq_half_delay u_hd (
      .clk(clk), .rst_n(rst_n), .half_en(pin_xdly[k]),
      .lvl_in(lvl_q[k]), .lvl_out(lvl_d[k])
    );
  end

  // ---------------- bus lanes, read capture, decode fields ----------------
  logic ad_drive_nxt;
  assign ad_drive_nxt = busy_nxt && (e_write || lvl_nxt[STB_ADV]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ad_oe  <= 1'b0;
      mem_ad_out <= '0;
      rd_data    <= '0;
      pin_nand   <= 1'b0;
      pin_cmd    <= 1'b0;
      pin_xdly   <= '0;
      pin_cs     <= '0;
    end else begin
      mem_ad_oe  <= ad_drive_nxt;
      mem_ad_out <= !ad_drive_nxt ? '0 : (e_write ? e_wdata : e_addr);
      if (oe_fall) rd_data <= mem_ad_in;
      if (accept) begin
        pin_nand <= e_nand;
        pin_cmd  <= e_cmd;
        pin_xdly <= e_xdly;
        pin_cs   <= e_cs;
      end
    end
  end

  // ---------------- pin polarity and decode ----------------
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign mem_cs_n[i] = !(lvl_d[STB_CS] && (pin_cs == CS_IW'(i)));
  end

  assign mem_adv_ale = pin_nand ? (lvl_d[STB_ADV] && !pin_cmd) : !lvl_d[STB_ADV];
  assign mem_be_cle  = pin_nand ? (lvl_d[STB_ADV] && pin_cmd)  : !lvl_d[STB_CS];
  assign mem_we_n    = !lvl_d[STB_WE];
  assign mem_oe_n    = !lvl_d[STB_OE];
endmodule

// File: rtl/asq_checker.sv
module asq_checker #(
  parameter int NUM_CS = 6,
  parameter int AD_W   = 16,
  parameter int LW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ad_oe,
  input logic              req_done,
  input logic [AD_W-1:0]   rd_data,
  input logic              busy,
  input logic              oe_fall,
  input logic [LW-1:0]     cfg_eff
);
  assert_single_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  assert_we_oe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_we_n && mem_oe_n && (&mem_cs_n) && !mem_ad_oe));

  assert_we_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_ad_oe);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_fall |=> $stable(rd_data));

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_eff));
endmodule

bind async_strobe_seq asq_checker #(
  .NUM_CS(NUM_CS), .AD_W(AD_W), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_ad_oe(mem_ad_oe), .req_done(req_done),
  .rd_data(rd_data), .busy(busy), .oe_fall(oe_fall), .cfg_eff(cfg_eff)
);

// File: tb/async_strobe_seq_tb.sv
module async_strobe_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string tag;
    bit wr, cmd, nd, g;
    int cs;
    bit [3:0] xd;
    int cs_on, cs_wo, cs_ro, adv_on, adv_wo, adv_ro, we_on, we_off, oe_on, oe_off, wcyc, rcyc;
    logic [15:0] addr, wdata;
  } acc_t;

  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_write = 0, req_cmd = 0;
  logic [2:0] req_cs = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, rd_data, mem_ad_out;
  logic [15:0] mem_ad_in = 16'h0F00;
  logic req_done, cfg_gran = 0, cfg_nand = 0;
  logic [3:0] cfg_xdly = 0;
  logic [4:0] cfg_cs_on = 0, cfg_cs_wr_off = 0, cfg_cs_rd_off = 0, cfg_adv_on = 0;
  logic [4:0] cfg_adv_wr_off = 0, cfg_adv_rd_off = 0, cfg_we_on = 0, cfg_we_off = 0;
  logic [4:0] cfg_oe_on = 0, cfg_oe_off = 0, cfg_wr_cycle = 0, cfg_rd_cycle = 0;
  logic [5:0] mem_cs_n;
  logic mem_adv_ale, mem_be_cle, mem_we_n, mem_oe_n, mem_ad_oe;

  int n_chk = 0, n_bad = 0;
  bit launch = 0;
  acc_t sb_q[$];
  logic [15:0] exp_rd = 0, last_ad = 0;

  async_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_cmd(req_cmd), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .rd_data(rd_data), .cfg_gran(cfg_gran), .cfg_nand(cfg_nand),
    .cfg_xdly(cfg_xdly), .cfg_cs_on(cfg_cs_on), .cfg_cs_wr_off(cfg_cs_wr_off),
    .cfg_cs_rd_off(cfg_cs_rd_off), .cfg_adv_on(cfg_adv_on), .cfg_adv_wr_off(cfg_adv_wr_off),
    .cfg_adv_rd_off(cfg_adv_rd_off), .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off),
    .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off), .cfg_wr_cycle(cfg_wr_cycle),
    .cfg_rd_cycle(cfg_rd_cycle), .mem_cs_n(mem_cs_n), .mem_adv_ale(mem_adv_ale),
    .mem_be_cle(mem_be_cle), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory bus read value walks every cycle, 1 ns after the rising edge
  initial forever begin
    @(posedge clk); #1;
    mem_ad_in = mem_ad_in + 16'h1111;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  function automatic int len_of(acc_t a);
    int c = a.wr ? a.wcyc : a.rcyc;
    if (c == 0) c = 1;
    return c * (a.g ? 2 : 1);
  endfunction

  function automatic bit lvl(acc_t a, int k, int t);
    int m = a.g ? 2 : 1;
    int on_c, off_c;
    bit gate = 1;
    case (k)
      0: begin on_c = a.cs_on;  off_c = a.wr ? a.cs_wo : a.cs_ro; end
      1: begin on_c = a.adv_on; off_c = a.wr ? a.adv_wo : a.adv_ro; end
      2: begin on_c = a.we_on;  off_c = a.we_off; gate = a.wr; end
      default: begin on_c = a.oe_on; off_c = a.oe_off; gate = !a.wr; end
    endcase
    if (t < 0 || t >= len_of(a) || !gate) return 0;
    return (t >= on_c * m) && (t < off_c * m);
  endfunction

  // {cs_n[5:0], adv_ale, be_cle, we_n, oe_n}
  function automatic logic [9:0] pins(acc_t a, int t, bit early);
    bit l [4];
    logic [5:0] csn;
    logic ale, be;
    for (int k = 0; k < 4; k++) l[k] = lvl(a, k, (early && a.xd[k]) ? t - 1 : t);
    for (int i = 0; i < 6; i++) csn[i] = !(l[0] && a.cs == i);
    ale = a.nd ? (l[1] && !a.cmd) : !l[1];
    be  = a.nd ? (l[1] && a.cmd) : !l[0];
    return {csn, ale, be, !l[2], !l[3]};
  endfunction

  // ---------------- monitor / scoreboard ----------------
  initial forever begin
    @(posedge clk);
    if (launch) begin : mon
      acc_t a;
      int L;
      logic [9:0] act_p, exp_p;
      logic exp_oe;
      logic [15:0] exp_ad;
      a = sb_q.pop_front();
      L = len_of(a);
      for (int t = 0; t <= L + 1; t++) begin
        if (t != 0) @(posedge clk);
        if (lvl(a, 3, t - 1) && !lvl(a, 3, t)) exp_rd = last_ad;
        #2;
        act_p = {mem_cs_n, mem_adv_ale, mem_be_cle, mem_we_n, mem_oe_n};
        exp_p = pins(a, t, 1);
        chk(act_p == exp_p, {a.tag, "/R5 early"}, 32'(act_p), 32'(exp_p));
        #5;
        act_p = {mem_cs_n, mem_adv_ale, mem_be_cle, mem_we_n, mem_oe_n};
        exp_p = pins(a, t, 0);
        chk(act_p[9:4] == exp_p[9:4], {a.tag, "/R6 cs"}, 32'(act_p[9:4]), 32'(exp_p[9:4]));
        chk(act_p[3:2] == exp_p[3:2], {a.tag, "/R9 latch"}, 32'(act_p[3:2]), 32'(exp_p[3:2]));
        chk(act_p[1:0] == exp_p[1:0], {a.tag, "/R3 we_oe"}, 32'(act_p[1:0]), 32'(exp_p[1:0]));
        chk(req_done == (t == L), {a.tag, "/R4 done"}, 32'(req_done), 32'(t == L));
        exp_oe = (t < L) && (a.wr || lvl(a, 1, t));
        exp_ad = !exp_oe ? 16'h0 : (a.wr ? a.wdata : a.addr);
        chk({mem_ad_oe, mem_ad_out} == {exp_oe, exp_ad}, {a.tag, "/R7 bus"},
            32'({mem_ad_oe, mem_ad_out}), 32'({exp_oe, exp_ad}));
        if (t == L + 1)
          chk(rd_data == exp_rd, {a.tag, "/R8 rdata"}, 32'(rd_data), 32'(exp_rd));
        last_ad = mem_ad_in;
      end
    end
  end

  // ---------------- driver ----------------
  function automatic acc_t base(string tag, bit wr);
    acc_t a;
    a.tag = tag; a.wr = wr; a.cmd = 0; a.nd = 0; a.g = 0; a.cs = 2; a.xd = 0;
    a.cs_on = 0; a.cs_wo = 9; a.cs_ro = 8; a.adv_on = 1; a.adv_wo = 3; a.adv_ro = 2;
    a.we_on = 2; a.we_off = 6; a.oe_on = 3; a.oe_off = 7; a.wcyc = 10; a.rcyc = 9;
    a.addr = 16'h1234; a.wdata = 16'hBEEF;
    return a;
  endfunction

  task automatic do_acc(input acc_t a, input bit poke);
    req_write = a.wr; req_cmd = a.cmd; req_cs = 3'(a.cs); req_addr = a.addr;
    req_wdata = a.wdata; cfg_gran = a.g; cfg_nand = a.nd; cfg_xdly = a.xd;
    cfg_cs_on = 5'(a.cs_on); cfg_cs_wr_off = 5'(a.cs_wo); cfg_cs_rd_off = 5'(a.cs_ro);
    cfg_adv_on = 5'(a.adv_on); cfg_adv_wr_off = 5'(a.adv_wo); cfg_adv_rd_off = 5'(a.adv_ro);
    cfg_we_on = 5'(a.we_on); cfg_we_off = 5'(a.we_off); cfg_oe_on = 5'(a.oe_on);
    cfg_oe_off = 5'(a.oe_off); cfg_wr_cycle = 5'(a.wcyc); cfg_rd_cycle = 5'(a.rcyc);
    sb_q.push_back(a);
    req_start = 1; launch = 1;
    @(negedge clk);
    req_start = 0; launch = 0;
    if (poke) begin
      // R10: a second start plus changed inputs in the middle of the access
      @(negedge clk);
      req_start = 1; req_write = !a.wr; req_cs = 3'd4; cfg_we_on = 0;
      cfg_wr_cycle = 5'd3; cfg_gran = 1; cfg_xdly = 4'hF; req_wdata = 16'h0000;
      @(negedge clk);
      req_start = 0;
    end
    while (!req_done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    acc_t a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({mem_cs_n, mem_adv_ale, mem_be_cle, mem_we_n, mem_oe_n} == 10'h3FF, "R11 pins",
        32'({mem_cs_n, mem_adv_ale, mem_be_cle, mem_we_n, mem_oe_n}), 32'h3FF);
    chk({mem_ad_oe, req_done, rd_data} == '0, "R11 bus/done/rd",
        32'({mem_ad_oe, req_done, rd_data}), 32'h0);

    a = base("R1", 1); do_acc(a, 0);
    a = base("R1", 0); a.cs = 0; do_acc(a, 0);
    a = base("R2", 1); a.g = 1; do_acc(a, 0);
    a = base("R2", 0); a.g = 1; a.cs = 1; do_acc(a, 0);
    a = base("R5", 0); a.xd = 4'hF; do_acc(a, 0);
    a = base("R5", 1); a.xd = 4'b0101; a.cs = 3; do_acc(a, 0);
    a = base("R9", 1); a.nd = 1; a.cmd = 1; a.xd = 4'b0010; do_acc(a, 0);
    a = base("R9", 1); a.nd = 1; a.cmd = 0; do_acc(a, 0);
    a = base("R9", 0); a.nd = 1; a.cmd = 0; a.g = 1; do_acc(a, 0);
    a = base("R1", 0); a.nd = 0; do_acc(a, 0);
    a = base("R6", 0); a.cs = 7; do_acc(a, 0);
    a = base("R6", 1); a.cs = 5; do_acc(a, 0);
    a = base("R4", 1); a.wcyc = 0; a.we_on = 0; a.we_off = 1; do_acc(a, 0);
    a = base("R4", 0); a.rcyc = 0; a.g = 1; a.oe_on = 0; a.oe_off = 1; do_acc(a, 0);
    a = base("R8", 0); a.oe_off = 12; do_acc(a, 0);
    a = base("R10", 1); do_acc(a, 1);
    a = base("R10", 0); a.cs = 1; do_acc(a, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule